// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog

This block is a single watchdog channel. A down-counter is loaded from a programmed length and steps down once per prescaler period. Each time the counter runs out, the channel moves one step along an escalation ladder. The first step raises a pending interrupt toward the application core. The second step sends a one-cycle interrupt pulse toward a management controller. The third step raises a reset request. A two-bit mode field selects how far the ladder may go. Software keeps the system alive by writing the kick location, which reloads the counter and returns the ladder to its first step.

The core interrupt has a pending flag that software clears by writing one to it, and an enable that software changes through separate set and clear locations. After each expiry that does not end in a reset, the counter reloads itself and keeps running. Once the reset request is raised, it stays high until the block itself is reset.

The register interface is a plain write strobe with an address and a combinational read path. There is no handshake. Word locations: 0 control, 1 kick, 2 pending, 3 enable-set, 4 enable-clear.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, the control word reads zero (mode off, length zero, count zero). The pending flag and the enable read zero. coreIrq, mgmtIrq and rstReq are low.
- R2: Control word (address 0) layout: mode in bits [1:0], management-interrupt enable in bit 2, length in bits [LEN_LSB +: LEN_W], live count in the next CNT_W bits. The count field is read-only, and writes to it are ignored.
- R3: Writing a word with bit 0 set to the kick location (address 1) loads the counter with the length in its upper LEN_W bits and zeros in the lower CNT_W-LEN_W bits. It also clears the prescaler. A kick works in any mode.
- R4: While running, the counter steps down once every 2^PRE_LOG2 clocks. An expiry occurs on the step that would bring the counter to zero, or on the first step when the counter is already zero. With length L, the first expiry falls max(L·2^(CNT_W-LEN_W),1)·2^PRE_LOG2 clocks after running starts from a cleared prescaler.
- R5: Mode 0 stops the channel: the counter holds, no expiry occurs, the prescaler is cleared and the ladder returns to its first step.
- R6: In mode 1, every expiry sets the core pending flag, and the counter reloads itself from the length and keeps counting.
- R7: In mode 2, the first expiry sets the core pending flag and the second produces a one-cycle mgmtIrq pulse. Later expiries produce nothing further.
- R8: In mode 3, the first expiry sets the core pending flag. The second produces an mgmtIrq pulse only when control bit 2 is set. The third raises rstReq, which then stays high until reset, even through kicks.
- R9: Writing a word with bit 0 set to the pending location (address 2) clears the pending flag. Writing 0 there has no effect. A new first-step expiry in the same cycle wins over the clear. The flag reads in bit 0.
- R10: The pending flag sets whether or not the interrupt is enabled. coreIrq is high exactly when both the pending flag and the enable are set. Writing bit 0 = 1 to address 3 sets the enable and to address 4 clears it. Both addresses read the enable in bit 0.
- R11: A kick returns the escalation ladder to its first step, so the next expiry again sets the core pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address for write and read |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data at addr |
| coreIrq | output | 1 | Core interrupt, pending AND enable |
| mgmtIrq | output | 1 | One-cycle management-controller interrupt pulse |
| rstReq | output | 1 | Sticky reset request |

## Verification
On every cycle, the assertions check the following:
- rstReq, once raised, stays high.
- Only one escalation step fires at a time.
- An mgmtIrq pulse only follows a mode that allows it.
- No expiry happens in mode 0, and the counter holds there.
- A kick loads the expected value and returns the ladder to its first step.
- The count never exceeds the largest reload value.
- The pending flag follows every first-step expiry.

Exact expiry timing can only be shown by the bench scenarios: the bench sweeps every length of a small configuration and derives the expected clock counts arithmetically. The same holds for the number and order of events in each mode, the gating by the management-interrupt enable, and the restart of the ladder after a kick.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_IRQ    = 2'd1,
    MODE_IRQ_FW = 2'd2,
    MODE_FULL   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    STG_FIRST  = 2'd0,
    STG_SECOND = 2'd1,
    STG_THIRD  = 2'd2,
    STG_DONE   = 2'd3
  } stage_e;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic reload;  // load counter from length, clear prescaler
    logic hold;    // channel stopped: clear prescaler, keep count
    logic run;     // advance prescaler and counter
  } cnt_cmd_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_KICK   = 3'd1;
  localparam logic [2:0] ADDR_PEND   = 3'd2;
  localparam logic [2:0] ADDR_EN_SET = 3'd3;
  localparam logic [2:0] ADDR_EN_CLR = 3'd4;

endpackage

// File: rtl/esc_wdog_count.sv
module esc_wdog_count
  import esc_wdog_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int LEN_W    = 16,
  parameter int PRE_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  input  logic [LEN_W-1:0] lenVal,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  localparam int LOW_W = CNT_W - LEN_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PRE_LOG2-1:0] pre;
  logic [CNT_W-1:0]    reloadVal;
  logic                tick;

  generate
    if (LOW_W > 0) begin : g_padLow
      assign reloadVal = {lenVal, {LOW_W{1'b0}}};
    end else begin : g_noPad
      assign reloadVal = CNT_W'(lenVal);
    end
  endgenerate

  assign tick   = cmd.run && (pre == {PRE_LOG2{1'b1}});
  assign expire = tick && !cmd.reload && (count <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre   <= '0;
      count <= '0;
    end else if (cmd.reload) begin
      pre   <= '0;
      count <= reloadVal;
    end else if (cmd.hold) begin
      pre   <= '0;
    end else if (cmd.run) begin
      pre <= pre + 1'b1;
      if (tick) begin
        count <= (count <= ONE) ? reloadVal : count - ONE;
      end
    end
  end

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |=> count == $past(reloadVal)); // R3

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    count <= {{LEN_W{1'b1}}, {LOW_W{1'b0}}}); // R4

  AST_STEP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !cmd.reload && !tick) |=> $stable(count)); // R4

  AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.hold && !cmd.reload) |=> $stable(count)); // R5

endmodule

// File: rtl/esc_wdog_ctrl.sv
module esc_wdog_ctrl
  import esc_wdog_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 24,
  parameter int LEN_W   = 16,
  parameter int LEN_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output cnt_cmd_t          cmd,
  output logic [LEN_W-1:0]  lenVal,
  output logic              coreIrq,
  output logic              mgmtIrq,
  output logic              rstReq
);

  localparam int CNT_LSB = LEN_LSB + LEN_W;

  mode_e  mode;
  stage_e stage, nextStage;
  logic   fwEn, pend, irqEn;
  logic   wrCtrl, kickWr, pendClr, enSetWr, enClrWr;
  logic   coreFire, fwFire, rstFire;

  assign wrCtrl  = wrEn && (addr == ADDR_CTRL);
  assign kickWr  = wrEn && (addr == ADDR_KICK)   && wrData[0];
  assign pendClr = wrEn && (addr == ADDR_PEND)   && wrData[0];
  assign enSetWr = wrEn && (addr == ADDR_EN_SET) && wrData[0];
  assign enClrWr = wrEn && (addr == ADDR_EN_CLR) && wrData[0];

  assign cmd.reload = kickWr;
  assign cmd.hold   = (mode == MODE_OFF);
  assign cmd.run    = (mode != MODE_OFF) && !rstReq;

  // escalation decision for the current expiry
  always_comb begin
    coreFire  = 1'b0;
    fwFire    = 1'b0;
    rstFire   = 1'b0;
    nextStage = stage;
    if (expire) begin
      unique case (mode)
        MODE_IRQ: begin
          coreFire = 1'b1;
        end
        MODE_IRQ_FW: begin
          if (stage == STG_FIRST) begin
            coreFire  = 1'b1;
            nextStage = STG_SECOND;
          end else if (stage == STG_SECOND) begin
            fwFire    = 1'b1;
            nextStage = STG_DONE;
          end
        end
        MODE_FULL: begin
          unique case (stage)
            STG_FIRST: begin
              coreFire  = 1'b1;
              nextStage = STG_SECOND;
            end
            STG_SECOND: begin
              fwFire    = fwEn;
              nextStage = STG_THIRD;
            end
            STG_THIRD: begin
              rstFire   = 1'b1;
              nextStage = STG_DONE;
            end
            default: nextStage = STG_DONE;
          endcase
        end
        default: nextStage = stage;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      fwEn    <= 1'b0;
      lenVal  <= '0;
      stage   <= STG_FIRST;
      pend    <= 1'b0;
      irqEn   <= 1'b0;
      mgmtIrq <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        mode   <= mode_e'(wrData[1:0]);
        fwEn   <= wrData[2];
        lenVal <= wrData[LEN_LSB +: LEN_W];
      end
      if (kickWr || mode == MODE_OFF) stage <= STG_FIRST;
      else                            stage <= nextStage;
      if (coreFire)     pend <= 1'b1;
      else if (pendClr) pend <= 1'b0;
      if (enSetWr)      irqEn <= 1'b1;
      else if (enClrWr) irqEn <= 1'b0;
      mgmtIrq <= fwFire;
      if (rstFire) rstReq <= 1'b1;
    end
  end

  assign coreIrq = pend && irqEn;

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdData[1:0]                = mode;
        rdData[2]                  = fwEn;
        rdData[LEN_LSB +: LEN_W]   = lenVal;
        rdData[CNT_LSB +: CNT_W]   = count;
      end
      ADDR_PEND:   rdData[0] = pend;
      ADDR_EN_SET: rdData[0] = irqEn;
      ADDR_EN_CLR: rdData[0] = irqEn;
      default:     rdData    = '0;
    endcase
  end

  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq); // R8

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({coreFire, fwFire, rstFire})); // R8

  AST_FW_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mgmtIrq) |-> ($past(mode) == MODE_IRQ_FW ||
                        ($past(mode) == MODE_FULL && $past(fwEn)))); // R7

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !expire); // R5

  AST_PEND_ON_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (expire && stage == STG_FIRST && mode != MODE_OFF) |=> pend); // R10

  AST_KICK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    kickWr |=> stage == STG_FIRST); // R11

endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import esc_wdog_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 24,
  parameter int PRE_LOG2 = 10,
  parameter int LEN_LSB  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              coreIrq,
  output logic              mgmtIrq,
  output logic              rstReq
);

  cnt_cmd_t         cmd;
  logic [LEN_W-1:0] lenVal;
  logic [CNT_W-1:0] count;
  logic             expire;

  esc_wdog_ctrl #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .LEN_W  (LEN_W),
    .LEN_LSB(LEN_LSB)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .count  (count),
    .expire (expire),
    .cmd    (cmd),
    .lenVal (lenVal),
    .coreIrq(coreIrq),
    .mgmtIrq(mgmtIrq),
    .rstReq (rstReq)
  );

  esc_wdog_count #(
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W),
    .PRE_LOG2(PRE_LOG2)
  ) i_count (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .lenVal(lenVal),
    .count (count),
    .expire(expire)
  );

endmodule

// File: tb/test_esc_watchdog.sv
`timescale 1ns/100ps
module test_esc_watchdog;

  localparam int DATA_W = 16, LEN_W = 4, CNT_W = 6, PRE_LOG2 = 2, LEN_LSB = 4;
  localparam int CNT_LSB = LEN_LSB + LEN_W;
  localparam int SCALE = 1 << (CNT_W - LEN_W);
  localparam int PER   = 1 << PRE_LOG2;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] addr = 0;
  logic [DATA_W-1:0] wrData = 0, rdData;
  logic coreIrq, mgmtIrq, rstReq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  esc_watchdog #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
                 .PRE_LOG2(PRE_LOG2), .LEN_LSB(LEN_LSB)) i_esc_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .coreIrq(coreIrq), .mgmtIrq(mgmtIrq), .rstReq(rstReq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input int d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = DATA_W'(d);
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic regRead(input logic [2:0] a, output int d);
    addr = a; #0.2;
    d = int'(rdData);
  endtask

  task automatic readCount(output int c);
    int d;
    regRead(3'd0, d);
    c = (d >> CNT_LSB) & ((1 << CNT_W) - 1);
  endtask

  task automatic doReset();
    rstN = 0; wrEn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
  endtask

  function automatic int ctrlWord(input int len, input int fw, input int mode);
    return (len << LEN_LSB) | (fw << 2) | mode;
  endfunction

  // start a channel: load length, kick, then select mode (run starts at that edge)
  task automatic startRun(input int len, input int fw, input int mode);
    regWrite(3'd0, ctrlWord(len, fw, 0));
    regWrite(3'd1, 1);
    regWrite(3'd2, 1);
    regWrite(3'd0, ctrlWord(len, fw, mode));
  endtask

  // watch for n cycles; record the cycle of the first core irq, mgmt pulses, rst
  task automatic watch(input int n, output int coreK, output int fwK, output int fwCnt,
                       output int rstK);
    coreK = 0; fwK = 0; fwCnt = 0; rstK = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (coreIrq && coreK == 0) coreK = k;
      if (mgmtIrq) begin fwCnt++; if (fwK == 0) fwK = k; end
      if (rstReq && rstK == 0) rstK = k;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d, c, exp, coreK, fwK, fwCnt, rstK;
    doReset();

    // R1 reset state
    regRead(3'd0, d); check(d == 0, "R1 ctrl", d, 0);
    regRead(3'd2, d); check(d == 0, "R1 pend", d, 0);
    regRead(3'd3, d); check(d == 0, "R1 enable", d, 0);
    check(!coreIrq && !mgmtIrq && !rstReq, "R1 outputs", {coreIrq, mgmtIrq, rstReq}, 0);

    // R2 field layout, count field read-only
    regWrite(3'd0, (6'h3F << CNT_LSB) | ctrlWord(10, 1, 0));
    regRead(3'd0, d);
    check((d & 3) == 0, "R2 mode", d & 3, 0);
    check(((d >> 2) & 1) == 1, "R2 fwEn", (d >> 2) & 1, 1);
    check(((d >> LEN_LSB) & 15) == 10, "R2 length", (d >> LEN_LSB) & 15, 10);
    readCount(c); check(c == 0, "R2 count read-only", c, 0);

    // R3 kick loads length in upper bits
    regWrite(3'd1, 1);
    readCount(c); check(c == 10 * SCALE, "R3 kick load", c, 10 * SCALE);
    regWrite(3'd1, 2);
    readCount(c); check(c == 10 * SCALE, "R3 kick needs bit0", c, 10 * SCALE);

    // R4 / R6 sweep all lengths in mode 1
    regWrite(3'd3, 1);
    for (int len = 0; len < 16; len++) begin
      exp = ((len == 0) ? 1 : len * SCALE) * PER;
      startRun(len, 0, 1);
      for (int k = 1; k <= exp; k++) begin
        @(posedge clk); #1;
        if (k == PER && len > 0) begin
          readCount(c); check(c == len * SCALE - 1, "R4 first step", c, len * SCALE - 1);
        end
        if (k == exp - 1) check(!coreIrq, "R4 no early expiry", coreIrq, 0);
        if (k == exp) begin
          check(coreIrq, "R4 expiry time", coreIrq, 1);
          readCount(c); check(c == len * SCALE, "R6 auto reload", c, len * SCALE);
        end
      end
      regWrite(3'd2, 1);
      for (int k = 1; k < exp; k++) begin
        @(posedge clk); #1;
        if (k == exp - 2 && exp > 2) check(!coreIrq, "R6 second early", coreIrq, 0);
        if (k == exp - 1) check(coreIrq, "R6 second expiry", coreIrq, 1);
      end
      regWrite(3'd0, ctrlWord(len, 0, 0));
    end

    // R7 mode 2
    doReset(); regWrite(3'd3, 1);
    startRun(1, 1, 2);
    watch(120, coreK, fwK, fwCnt, rstK);
    check(coreK == 16, "R7 core first", coreK, 16);
    check(fwK == 32, "R7 mgmt second", fwK, 32);
    check(fwCnt == 1, "R7 single mgmt", fwCnt, 1);
    check(rstK == 0, "R7 no reset", rstK, 0);

    // R8 mode 3 with management interrupt enabled
    doReset(); regWrite(3'd3, 1);
    startRun(1, 1, 3);
    regRead(3'd0, d); check((d & 3) == 3, "R2 mode readback", d & 3, 3);
    watch(80, coreK, fwK, fwCnt, rstK);
    check(coreK == 16, "R8 core first", coreK, 16);
    check(fwK == 32 && fwCnt == 1, "R8 mgmt second", fwK, 32);
    check(rstK == 48, "R8 reset third", rstK, 48);
    regWrite(3'd1, 1);
    repeat (40) @(posedge clk); #1;
    check(rstReq, "R8 reset sticky", rstReq, 1);

    // R8 mode 3 with management interrupt disabled
    doReset(); regWrite(3'd3, 1);
    startRun(1, 0, 3);
    watch(60, coreK, fwK, fwCnt, rstK);
    check(coreK == 16, "R8 core first nofw", coreK, 16);
    check(fwCnt == 0, "R8 mgmt gated", fwCnt, 0);
    check(rstK == 48, "R8 reset third nofw", rstK, 48);

    // R11 kick restarts the ladder
    doReset(); regWrite(3'd3, 1);
    startRun(1, 0, 2);
    watch(16, coreK, fwK, fwCnt, rstK);
    check(coreK == 16, "R11 first expiry", coreK, 16);
    regWrite(3'd2, 1);
    regWrite(3'd1, 1);
    watch(20, coreK, fwK, fwCnt, rstK);
    check(coreK == 16, "R11 core again after kick", coreK, 16);
    check(fwCnt == 0, "R11 no mgmt after kick", fwCnt, 0);

    // R10 pend sets while disabled; R9 write-one-to-clear
    doReset();
    startRun(0, 0, 1);
    watch(8, coreK, fwK, fwCnt, rstK);
    check(coreK == 0, "R10 masked irq", coreK, 0);
    regWrite(3'd0, ctrlWord(0, 0, 0));
    regRead(3'd2, d); check(d == 1, "R10 pend while disabled", d, 1);
    regWrite(3'd2, 0);
    regRead(3'd2, d); check(d == 1, "R9 write zero ignored", d, 1);
    regWrite(3'd3, 1); #0.2;
    check(coreIrq, "R10 enable set", coreIrq, 1);
    regRead(3'd4, d); check(d == 1, "R10 enable readback", d, 1);
    regWrite(3'd4, 1); #0.2;
    check(!coreIrq, "R10 enable clear", coreIrq, 0);
    regWrite(3'd3, 1);
    regWrite(3'd2, 1);
    regRead(3'd2, d); check(d == 0, "R9 clear", d, 0);
    check(!coreIrq, "R9 irq drops", coreIrq, 0);

    // R5 mode 0 holds count and clears prescaler
    doReset(); regWrite(3'd3, 1);
    startRun(3, 0, 1);
    repeat (10) @(posedge clk); #1;
    readCount(c); check(c == 3 * SCALE - 2, "R5 running", c, 3 * SCALE - 2);
    regWrite(3'd0, ctrlWord(3, 0, 0));
    repeat (40) @(posedge clk); #1;
    readCount(c); check(c == 3 * SCALE - 2, "R5 held", c, 3 * SCALE - 2);
    check(!coreIrq, "R5 no expiry", coreIrq, 0);
    regWrite(3'd0, ctrlWord(3, 0, 1));
    repeat (PER - 1) @(posedge clk); #1;
    readCount(c); check(c == 3 * SCALE - 2, "R5 prescaler cleared", c, 3 * SCALE - 2);
    @(posedge clk); #1;
    readCount(c); check(c == 3 * SCALE - 3, "R5 resume step", c, 3 * SCALE - 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule